// File: doc/BRIEF.md
# Multi-Source Host-Link Transmit Packer

This block gathers 32-bit words offered by several independent source queues (for example a packet stream, configuration responses and a loopback path) and packs them into 256-bit frames for a host link. Each frame carries seven 32-bit payload slots and one 32-bit status word. For each slot, the status word records whether the slot holds a word, which source supplied it, and whether that word ended a packet. A receiver can therefore split the words back to their sources and rebuild packet boundaries.

Sources are served one word per cycle under round-robin arbitration, so words from different sources can share a frame. The block sends a frame as soon as all seven slots are filled. When traffic stops with a frame only partly filled, a timeout sends it anyway, with the empty slots marked invalid, which bounds the latency. The source queues work in first-word-fall-through fashion: `src_valid` means the head word is present, and a pulse on `src_pop` consumes it on the same clock edge.

Top module: `hl_tx_packer`

## Requirements
- R1: After reset, `frm_valid` is 0 and `src_pop` is all zeros while no source is valid.
- R2: Bits 31:28 of every emitted frame (the top nibble of the status word) hold the constant 4'hA.
- R3: The status word is `frm_data[31:0]`. Slot i (i = 0..6) occupies `frm_data[32*(i+1) +: 32]` and is described by status nibble `frm_data[4*i +: 4]`, which reads {valid, last, source_id[1:0]}. Valid slots always start at slot 0 and are contiguous.
- R4: Once the seventh word of a frame is accepted, `frm_valid` is 1 for exactly the following cycle, carrying all seven words.
- R5: `src_pop` has at most one bit set, only for a source whose `src_valid` is 1, and has a bit set whenever any source is valid.
- R6: Arbitration is round-robin. The granted source is the first valid one after the previously granted index, counting upward and wrapping. After reset, source 0 has first priority.
- R7: When a frame is partly filled and no word is accepted for IDLE_LIMIT (default 64) consecutive edges, the frame is emitted. Its unused slot nibbles are 4'h0.
- R8: While the frame being filled is empty, no frame is emitted, however long the block stays idle.
- R9: Accepted words fill the slots in acceptance order, starting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | NSRC | Head word present, one bit per source |
| src_data | input | 32*NSRC | Head words; source s at bits 32*s+:32 |
| src_last | input | NSRC | Head word ends a packet, one bit per source |
| src_pop | output | NSRC | One-hot consume strobe for the granted source |
| frm_valid | output | 1 | Frame valid for one cycle |
| frm_data | output | 256 | Status word in 31:0, slots 0..6 above |

## Verification
If the slot counter is wrong, the very next frame shows it: the frame appears one cycle early or late, or it has a gap or an overlap in its valid nibbles. If the arbiter pointer is corrupted, `src_pop` is wrong in the same cycle, because the bench predicts every grant from the requirement. If the idle counter is faulty, a partial frame moves away from the exact edge IDLE_LIMIT cycles after the last accept, or a spurious frame appears while the block is empty. Errors in the data path show up as mismatched words or nibbles in the first frame that contains the affected slot.

// File: rtl/hl_tx_packer.sv
module hl_tx_packer #(
  parameter int NSRC       = 3,
  parameter int IDLE_LIMIT = 64,
  parameter logic [3:0] MAGIC = 4'hA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_valid,
  input  logic [32*NSRC-1:0]   src_data,
  input  logic [NSRC-1:0]      src_last,
  output logic [NSRC-1:0]      src_pop,
  output logic                 frm_valid,
  output logic [255:0]         frm_data
);
  localparam int SLOTS = 7;
  localparam int PW    = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int IW    = $clog2(IDLE_LIMIT);

  logic [PW-1:0] ptr, gidx;
  logic          any;
  logic [2:0]    cnt;
  logic [IW-1:0] idle;
  logic [31:0]   slot_d [SLOTS];
  logic [3:0]    slot_n [SLOTS];
  logic [31:0]   nd [SLOTS];
  logic [3:0]    nn [SLOTS];
  logic [31:0]   wd;
  logic [3:0]    nib;
  logic [255:0]  fr;
  logic          emit_full, emit_to;

  always_comb begin
    any  = 1'b0;
    gidx = ptr;
    for (int k = 1; k <= NSRC; k++) begin
      if (!any && src_valid[(int'(ptr) + k) % NSRC]) begin
        any  = 1'b1;
        gidx = PW'((int'(ptr) + k) % NSRC);
      end
    end
    src_pop = '0;
    src_pop[gidx] = any;
  end

  assign wd  = src_data[32*int'(gidx) +: 32];
  assign nib = {1'b1, src_last[gidx], 2'(gidx)};

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      nd[i] = slot_d[i];
      nn[i] = slot_n[i];
    end
    if (any) begin
      nd[cnt] = wd;
      nn[cnt] = nib;
    end
    fr = '0;
    fr[31:28] = MAGIC;
    for (int i = 0; i < SLOTS; i++) begin
      fr[4*i +: 4]        = nn[i];
      fr[32*(i+1) +: 32]  = nd[i];
    end
  end

  assign emit_full = any && (cnt == 3'(SLOTS-1));
  assign emit_to   = !any && (cnt != 3'd0) && (idle == IW'(IDLE_LIMIT-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= PW'(NSRC-1);
      cnt       <= '0;
      idle      <= '0;
      frm_valid <= 1'b0;
      frm_data  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        slot_d[i] <= '0;
        slot_n[i] <= '0;
      end
    end else begin
      frm_valid <= emit_full || emit_to;
      if (any) ptr <= gidx;
      if (emit_full || emit_to) begin
        frm_data <= fr;
        cnt      <= '0;
        idle     <= '0;
        for (int i = 0; i < SLOTS; i++) slot_n[i] <= '0;
      end else if (any) begin
        slot_d[cnt] <= wd;
        slot_n[cnt] <= nib;
        cnt         <= cnt + 3'd1;
        idle        <= '0;
      end else if (cnt != 3'd0) begin
        idle <= idle + IW'(1);
      end
    end
  end
endmodule

// File: rtl/hl_tx_packer_chk.sv
module hl_tx_packer_chk #(
  parameter int NSRC = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NSRC-1:0]    src_valid,
  input logic [NSRC-1:0]    src_pop,
  input logic               frm_valid,
  input logic [255:0]       frm_data
);
  logic [6:0] vbits;
  assign vbits = {frm_data[27], frm_data[23], frm_data[19], frm_data[15],
                  frm_data[11], frm_data[7], frm_data[3]};

  a_r5_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_pop));
  a_r5_pop_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pop & ~src_valid) == '0);
  a_r5_pop_when_any: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_valid) |-> (|src_pop));
  a_r2_magic: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> frm_data[31:28] == 4'hA);
  a_r3_slots_packed: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (((vbits + 7'd1) & vbits) == 7'd0));
  a_r8_no_empty_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> vbits != 7'd0);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);
endmodule

bind hl_tx_packer hl_tx_packer_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_pop(src_pop),
  .frm_valid(frm_valid), .frm_data(frm_data)
);

// File: tb/tb_hl_tx_packer.sv
`timescale 1ns/1ps
module tb_hl_tx_packer;
  localparam int NS = 3;
  localparam int IL = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS-1:0]     src_valid = '0;
  logic [32*NS-1:0]  src_data = '0;
  logic [NS-1:0]     src_last = '0;
  logic [NS-1:0]     src_pop;
  logic              frm_valid;
  logic [255:0]      frm_data;

  hl_tx_packer #(.NSRC(NS), .IDLE_LIMIT(IL)) dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_last(src_last), .src_pop(src_pop), .frm_valid(frm_valid),
    .frm_data(frm_data));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] qd [NS][32];
  logic        ql [NS][32];
  int qn [NS], qh [NS];
  int bptr = NS-1;
  logic [31:0] ed [7];
  logic [3:0]  en [7];
  int cur_n = 0, idle = 0, frames = 0;
  bit pend = 0;
  string pend_req = "R4";
  int pend_n = 0;
  logic [31:0] pd [7];
  logic [31:0] pstat;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input int s, input logic [31:0] d, input logic l);
    qd[s][qn[s]] = d;
    ql[s][qn[s]] = l;
    qn[s]++;
  endtask

  task automatic close_frame(input string req);
    pstat = {4'hA, 28'h0};
    for (int i = 0; i < 7; i++) begin
      pstat[4*i +: 4] = (i < cur_n) ? en[i] : 4'h0;
      pd[i] = ed[i];
    end
    pend_n = cur_n; pend = 1; pend_req = req; cur_n = 0; idle = 0;
  endtask

  task automatic step();
    int eg;
    logic [NS-1:0] ep;
    @(negedge clk);
    chk(frm_valid == pend, pend_req, "frame strobe", 256'(frm_valid), 256'(pend));
    if (frm_valid) frames++;
    if (pend && frm_valid) begin
      chk(frm_data[31:28] == 4'hA, "R2", "magic", 256'(frm_data[31:28]), 256'hA);
      chk(frm_data[31:0] == pstat, "R3", "status word", 256'(frm_data[31:0]), 256'(pstat));
      for (int i = 0; i < pend_n; i++)
        chk(frm_data[32*(i+1) +: 32] == pd[i], "R9", "slot word",
            256'(frm_data[32*(i+1) +: 32]), 256'(pd[i]));
    end
    pend = 0;
    for (int s = 0; s < NS; s++) begin
      src_valid[s] = qh[s] < qn[s];
      src_data[32*s +: 32] = (qh[s] < qn[s]) ? qd[s][qh[s]] : 32'h0;
      src_last[s] = (qh[s] < qn[s]) ? ql[s][qh[s]] : 1'b0;
    end
    #1;
    eg = -1;
    for (int k = 1; k <= NS; k++)
      if (eg < 0 && src_valid[(bptr + k) % NS]) eg = (bptr + k) % NS;
    ep = '0;
    if (eg >= 0) ep[eg] = 1'b1;
    chk(src_pop == ep, (eg >= 0) ? "R6" : "R5", "pop", 256'(src_pop), 256'(ep));
    if (eg >= 0) begin
      ed[cur_n] = qd[eg][qh[eg]];
      en[cur_n] = {1'b1, ql[eg][qh[eg]], 2'(eg)};
      cur_n++; qh[eg]++; bptr = eg; idle = 0;
      if (cur_n == 7) close_frame("R4");
    end else if (cur_n > 0) begin
      idle++;
      if (idle == IL) close_frame("R7");
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(frm_valid == 1'b0, "R1", "frm_valid after reset", 256'(frm_valid), 256'h0);
    chk(src_pop == '0, "R1", "src_pop after reset", 256'(src_pop), 256'h0);
  endtask

  task automatic t_single_full();
    for (int i = 0; i < 7; i++) push(0, 32'h1000_0000 + i, 1'b0);
    run(10);
  endtask

  task automatic t_round_robin();
    for (int i = 0; i < 5; i++)
      for (int s = 0; s < NS; s++) push(s, 32'h2000_0000 + 32'(s*256 + i), 1'b0);
    run(90);
  endtask

  task automatic t_timeout();
    int f0;
    f0 = frames;
    push(1, 32'hCAFE_0001, 1'b0);
    push(1, 32'hCAFE_0002, 1'b1);
    push(2, 32'hCAFE_0003, 1'b0);
    run(IL + 10);
    chk(frames == f0 + 1, "R7", "partial frame count", 256'(frames), 256'(f0 + 1));
  endtask

  task automatic t_last_marks();
    push(0, 32'hA0A0_0001, 1'b0);
    push(0, 32'hA0A0_0002, 1'b1);
    push(2, 32'hB0B0_0001, 1'b1);
    push(1, 32'hC0C0_0001, 1'b1);
    push(2, 32'hB0B0_0002, 1'b0);
    push(0, 32'hA0A0_0003, 1'b1);
    push(1, 32'hC0C0_0002, 1'b0);
    push(2, 32'hB0B0_0003, 1'b1);
    run(IL + 20);
  endtask

  task automatic t_idle_empty();
    int f0;
    f0 = frames;
    run(3 * IL);
    chk(frames == f0, "R8", "no frame while empty", 256'(frames), 256'(f0));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single_full();
    t_round_robin();
    t_timeout();
    t_last_marks();
    t_idle_empty();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule